// File: doc/BRIEF.md
# Three-Wire Nibble Register Bus Master

This block is the bit-level master for a slow three-wire register bus made of a chip-enable line, a serial clock that rests high, and a single bidirectional data line. A host issues one register access at a time over a parallel request port: a 4-bit register address, a direction flag and, for writes, a 4-bit value. The master serialises the access into 8-bit frames that carry the address or data nibble together with flag bits. For a read, it turns the data line around and clocks a byte in from the device. The low nibble of that byte is returned on the response port.

The data line leaves the block as three separate signals (driven value, drive enable, received value), so that the pad cell can sit outside the block. Chip enable is under the control of the host sequencer and only passes through this block. The length of every clock phase comes from a tick counter. Its cycle count is derived from the system clock period and a minimum phase time of 700 ns, rounded up.

The request port follows valid/ready rules. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the master is idle, so the requester is held off for the whole access. The requester may withdraw or change a request that has not been accepted. The response port cannot be back-pressured. `rsp_valid` is a single-cycle pulse, and the consumer must take `rsp_rdata` in that cycle.

Top module: `triwire_nib_master`

## Requirements
- R1: While and right after synchronous reset, `sclk` is 1, `sdo_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is accepted only on a cycle with `req_valid` and `req_ready` both high. `req_ready` stays 0 from the cycle after acceptance until the response pulse has ended. A request presented while the master is busy produces no frame and no response.
- R3: Every frame is 8 bits, most significant bit first. The device takes each bit on the falling edge of `sclk`. `sdo` changes only while `sclk` is high, never during a low phase.
- R4: Within a frame, every low phase of `sclk` lasts exactly PHASE_CYC = ceil(700 / SYS_CLK_NS) system cycles. Every high phase between two bits of the same frame also lasts exactly PHASE_CYC cycles.
- R5: A write sends two frames. The first is 0x20 OR addr (address flag at bit 5). The second is 0x10 OR wdata (data flag at bit 4).
- R6: A read sends one frame, 0x60 OR addr (read flag at bit 6, address flag at bit 5), and then clocks 8 bits in from `sdi`, most significant first. `rsp_rdata` is the low nibble of that byte.
- R7: Each input bit is sampled on `sdi` in the last cycle of its high phase, just before `sclk` is driven low.
- R8: On a transmitted frame, `sdo_oe` rises one cycle after the first bit appears on `sdo`, while `sclk` is high. It stays 1 through all 8 bits and is 0 by the time `sclk` returns high after the last bit. During the 8 input bits of a read, `sdo_oe` is 0.
- R9: Each accepted request yields exactly one single-cycle `rsp_valid` pulse. For a write, `rsp_rdata` is 0 during that pulse.
- R10: `ce_out` equals `ce_in` at all times.
- R11: A reset during an access abandons it. One cycle later `sclk` is 1, `sdo_oe` is 0 and the master accepts a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Master idle, request can be taken |
| req_is_read | input | 1 | 1 selects a register read, 0 a register write |
| req_addr | input | 4 | Register address |
| req_wdata | input | 4 | Write value |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 4 | Read value (0 for writes) during `rsp_valid` |
| ce_in | input | 1 | Chip enable from the host sequencer |
| ce_out | output | 1 | Chip enable to the device |
| sclk | output | 1 | Serial clock, rests high |
| sdo | output | 1 | Serial data driven towards the device |
| sdo_oe | output | 1 | Drive enable for the data line |
| sdi | input | 1 | Serial data received from the device |

## Verification
The test uses writes with addresses and values at both ends of the nibble range (0x0 and 0xF) and in between. A wrong flag bit, a swapped frame order or an LSB-first shift would each show up in a different frame byte. The read bytes returned by the modelled device have different high and low nibbles, including 0xF0 and 0x3C, which separates correct masking from returning the wrong half. During every input bit the device first drives the complement of the bit and corrects it only halfway through the high phase, so an early sample returns inverted data. Further runs hold a competing request during a busy access and apply reset in the middle of a write frame while the drive enable is on. These show that the busy master ignores the competing request and that an abandoned access is cleanly dropped.

// File: rtl/triwire_pkg.sv
package triwire_pkg;

  localparam int FRAME_W   = 8;
  localparam int NIB_W     = 4;
  localparam int BIT_IDX_W = $clog2(FRAME_W);
  localparam int PAD_W     = FRAME_W - NIB_W;

  // flag bits decoded by the device inside every frame
  localparam logic [FRAME_W-1:0] FLG_READ = 8'h40;
  localparam logic [FRAME_W-1:0] FLG_ADDR = 8'h20;
  localparam logic [FRAME_W-1:0] FLG_DATA = 8'h10;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_HIGH,
    ENG_LOW
  } eng_state_t;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_CMD_GO,
    SEQ_CMD_WAIT,
    SEQ_TAIL_GO,
    SEQ_TAIL_WAIT,
    SEQ_RESP
  } seq_state_t;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/triwire_phase_timer.sv
module triwire_phase_timer #(
  parameter int PHASE_CYC = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);

  generate
    if (PHASE_CYC <= 1) begin : g_single
      assign tick = run;
    end else begin : g_count
      localparam int CNT_W = $clog2(PHASE_CYC);
      logic [CNT_W-1:0] cnt;

      assign tick = run && (cnt == CNT_W'(PHASE_CYC - 1));

      always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
      end
    end
  endgenerate

endmodule

// File: rtl/triwire_frame_engine.sv
module triwire_frame_engine
  import triwire_pkg::*;
#(
  parameter int PHASE_CYC = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               tx_mode,
  input  logic [FRAME_W-1:0] tx_byte,
  input  logic               sdi,
  output logic               done,
  output logic [NIB_W-1:0]   rx_nib,
  output logic               sclk,
  output logic               sdo,
  output logic               sdo_oe
);

  eng_state_t           st;
  logic [FRAME_W-1:0]   sh;
  logic [BIT_IDX_W-1:0] left;
  logic                 tx_q;
  logic                 first;
  logic                 tick;
  logic                 sclk_q, sdo_q, oe_q, done_q;
  logic [NIB_W-1:0]     rx_q;

  triwire_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (st != ENG_IDLE),
    .tick (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ENG_IDLE;
      sh     <= '0;
      left   <= '0;
      tx_q   <= 1'b0;
      first  <= 1'b0;
      sclk_q <= 1'b1;
      sdo_q  <= 1'b0;
      oe_q   <= 1'b0;
      done_q <= 1'b0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ENG_IDLE: begin
          if (start) begin
            st    <= ENG_HIGH;
            tx_q  <= tx_mode;
            sh    <= tx_byte;
            left  <= BIT_IDX_W'(FRAME_W - 1);
            first <= 1'b1;
            sdo_q <= tx_mode ? tx_byte[FRAME_W-1] : 1'b0;
          end
        end
        ENG_HIGH: begin
          // drive enable follows the first presented bit by one cycle
          if (first && tx_q) oe_q <= 1'b1;
          first <= 1'b0;
          if (tick) begin
            sclk_q <= 1'b0;
            st     <= ENG_LOW;
            if (!tx_q) rx_q <= {rx_q[NIB_W-2:0], sdi};
          end
        end
        ENG_LOW: begin
          if (tick) begin
            sclk_q <= 1'b1;
            if (left == '0) begin
              st     <= ENG_IDLE;
              oe_q   <= 1'b0;
              done_q <= 1'b1;
            end else begin
              left  <= left - 1'b1;
              sh    <= {sh[FRAME_W-2:0], 1'b0};
              sdo_q <= tx_q ? sh[FRAME_W-2] : 1'b0;
              st    <= ENG_HIGH;
            end
          end
        end
        default: st <= ENG_IDLE;
      endcase
    end
  end

  assign done   = done_q;
  assign rx_nib = rx_q;
  assign sclk   = sclk_q;
  assign sdo    = sdo_q;
  assign sdo_oe = oe_q;

endmodule

// File: rtl/triwire_sequencer.sv
module triwire_sequencer
  import triwire_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_is_read,
  input  logic [NIB_W-1:0]   req_addr,
  input  logic [NIB_W-1:0]   req_wdata,
  output logic               req_ready,
  output logic               rsp_valid,
  output logic [NIB_W-1:0]   rsp_rdata,
  input  logic               eng_done,
  input  logic [NIB_W-1:0]   eng_rx_nib,
  output logic               eng_start,
  output logic               eng_tx_mode,
  output logic [FRAME_W-1:0] eng_tx_byte
);

  seq_state_t       st;
  logic             rd_q;
  logic [NIB_W-1:0] addr_q, wdata_q, rdata_q;

  assign req_ready   = (st == SEQ_IDLE);
  assign rsp_valid   = (st == SEQ_RESP);
  assign rsp_rdata   = rdata_q;
  assign eng_start   = (st == SEQ_CMD_GO) || (st == SEQ_TAIL_GO);
  assign eng_tx_mode = (st == SEQ_CMD_GO) || !rd_q;

  always_comb begin
    if (st == SEQ_CMD_GO) begin
      eng_tx_byte = {{PAD_W{1'b0}}, addr_q} | FLG_ADDR;
      if (rd_q) eng_tx_byte = eng_tx_byte | FLG_READ;
    end else begin
      eng_tx_byte = {{PAD_W{1'b0}}, wdata_q} | FLG_DATA;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SEQ_IDLE;
      rd_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (st)
        SEQ_IDLE: begin
          if (req_valid) begin
            rd_q    <= req_is_read;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            rdata_q <= '0;
            st      <= SEQ_CMD_GO;
          end
        end
        SEQ_CMD_GO:   st <= SEQ_CMD_WAIT;
        SEQ_CMD_WAIT: if (eng_done) st <= SEQ_TAIL_GO;
        SEQ_TAIL_GO:  st <= SEQ_TAIL_WAIT;
        SEQ_TAIL_WAIT: begin
          if (eng_done) begin
            if (rd_q) rdata_q <= eng_rx_nib;
            st <= SEQ_RESP;
          end
        end
        SEQ_RESP: st <= SEQ_IDLE;
        default:  st <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/triwire_nib_master.sv
module triwire_nib_master
  import triwire_pkg::*;
#(
  parameter int SYS_CLK_NS   = 30,
  parameter int MIN_PHASE_NS = 700
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_is_read,
  input  logic [NIB_W-1:0] req_addr,
  input  logic [NIB_W-1:0] req_wdata,
  output logic             rsp_valid,
  output logic [NIB_W-1:0] rsp_rdata,
  input  logic             ce_in,
  output logic             ce_out,
  output logic             sclk,
  output logic             sdo,
  output logic             sdo_oe,
  input  logic             sdi
);

  localparam int PHASE_CYC = ceil_div(MIN_PHASE_NS, SYS_CLK_NS);

  logic               eng_start, eng_tx_mode, eng_done;
  logic [FRAME_W-1:0] eng_tx_byte;
  logic [NIB_W-1:0]   eng_rx_nib;

  assign ce_out = ce_in;

  triwire_sequencer u_seq (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_is_read (req_is_read),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .eng_done    (eng_done),
    .eng_rx_nib  (eng_rx_nib),
    .eng_start   (eng_start),
    .eng_tx_mode (eng_tx_mode),
    .eng_tx_byte (eng_tx_byte)
  );

  triwire_frame_engine #(.PHASE_CYC(PHASE_CYC)) u_eng (
    .clk     (clk),
    .rst     (rst),
    .start   (eng_start),
    .tx_mode (eng_tx_mode),
    .tx_byte (eng_tx_byte),
    .sdi     (sdi),
    .done    (eng_done),
    .rx_nib  (eng_rx_nib),
    .sclk    (sclk),
    .sdo     (sdo),
    .sdo_oe  (sdo_oe)
  );

endmodule

// File: rtl/triwire_nib_master_chk.sv
module triwire_nib_master_chk #(
  parameter int SYS_CLK_NS   = 30,
  parameter int MIN_PHASE_NS = 700
) (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_valid,
  input logic sclk,
  input logic sdo,
  input logic sdo_oe
);

  localparam int PHASE_CYC = (MIN_PHASE_NS + SYS_CLK_NS - 1) / SYS_CLK_NS;

  int unsigned low_run;
  logic        rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst)        low_run <= 0;
    else if (!sclk) low_run <= low_run + 1;
    else            low_run <= 0;
  end

  // R1 R11
  always @(negedge clk) begin
    if (rst_q === 1'b1) begin
      reset_state_chk: assert (sclk && !sdo_oe && req_ready && !rsp_valid);
    end
  end

  // R3
  sdo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sclk |-> $stable(sdo));

  // R4
  low_phase_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> (low_run == PHASE_CYC));

  // R8
  oe_after_bit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sdo_oe) |-> (sclk && $stable(sdo)));

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R2 R9
  rsp_not_idle_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);

endmodule

bind triwire_nib_master triwire_nib_master_chk #(
  .SYS_CLK_NS   (SYS_CLK_NS),
  .MIN_PHASE_NS (MIN_PHASE_NS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .sclk      (sclk),
  .sdo       (sdo),
  .sdo_oe    (sdo_oe)
);

// File: tb/triwire_nib_master_test.sv
`timescale 1ns/1ps
module triwire_nib_master_test;

  localparam int CLK_NS = 30;
  localparam int MIN_NS = 700;
  localparam int PH     = (MIN_NS + CLK_NS - 1) / CLK_NS;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0, req_is_read = 1'b0;
  logic [3:0] req_addr = 4'h0, req_wdata = 4'h0;
  logic       ce_in = 1'b0, sdi = 1'b0;
  logic       req_ready, rsp_valid, ce_out, sclk, sdo, sdo_oe;
  logic [3:0] rsp_rdata;

  always #(CLK_NS / 2.0) clk = ~clk;

  triwire_nib_master #(.SYS_CLK_NS(CLK_NS), .MIN_PHASE_NS(MIN_NS)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_is_read(req_is_read), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ce_in(ce_in), .ce_out(ce_out),
    .sclk(sclk), .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi)
  );

  int n_tests = 0, n_fail = 0, rsp_seen = 0;
  logic [7:0] exp_frames[$];
  logic [3:0] exp_rsp[$];
  logic [7:0] slv_rbyte = 8'h00;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- device model on the serial side ----------------
  int       bitn = 0;
  logic [7:0] shreg = 8'h00;
  bit       in_rd = 0, tx_ended = 0, fell_valid = 0, oe_all = 1, oe_any = 0;
  realtime  t_rise = 0.0, t_fall = 0.0;

  always @(posedge rst) begin
    bitn = 0; in_rd = 0; tx_ended = 0; fell_valid = 0;
  end

  always @(negedge sclk) begin
    if (!rst) begin
      t_fall = $realtime;
      if (bitn > 0)  // R4 high phase between bits
        check($rtoi((t_fall - t_rise) / CLK_NS + 0.5) == PH, "R4", "high phase cycles",
              $rtoi((t_fall - t_rise) / CLK_NS + 0.5), PH);
      if (bitn == 0) begin oe_all = 1; oe_any = 0; end
      shreg  = {shreg[6:0], sdo};
      oe_all = oe_all & sdo_oe;
      oe_any = oe_any | sdo_oe;
      fell_valid = 1;
      bitn++;
      if (bitn == 8) begin
        bitn = 0;
        if (in_rd) begin
          check(!oe_any, "R8", "drive enable during input bits", oe_any, 0);
          in_rd = 0;
        end else begin
          check(oe_all, "R8", "drive enable over sent frame", oe_all, 1);
          if (exp_frames.size() == 0) begin
            check(0, "R2", "unexpected frame", shreg, 0);
          end else begin
            automatic logic [7:0] e = exp_frames.pop_front();
            check(shreg == e, e[6] ? "R3 R6" : "R3 R5", "frame byte", shreg, e);
          end
          tx_ended = 1;
          if (shreg[6]) in_rd = 1;
        end
      end
    end
  end

  always @(posedge sclk) begin
    t_rise = $realtime;
    if (fell_valid && !rst)  // R4 low phase
      check($rtoi((t_rise - t_fall) / CLK_NS + 0.5) == PH, "R4", "low phase cycles",
            $rtoi((t_rise - t_fall) / CLK_NS + 0.5), PH);
    fell_valid = 0;
    if (tx_ended) begin
      #1;
      check(!sdo_oe, "R8", "drive enable after last bit", sdo_oe, 0);
      tx_ended = 0;
    end
    if (in_rd && !rst) begin
      automatic int idx = 7 - bitn;
      sdi = ~slv_rbyte[idx];  // R7: wrong value early in the high phase
      repeat (PH / 2) @(posedge clk);
      sdi = slv_rbyte[idx];
    end
  end

  // ---------------- response monitor ----------------
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      rsp_seen++;
      if (exp_rsp.size() == 0) begin
        check(0, "R9", "unexpected response", rsp_rdata, 0);
      end else begin
        automatic logic [3:0] e = exp_rsp.pop_front();
        check(rsp_rdata == e, "R6 R7 R9", "response data", rsp_rdata, e);
      end
    end
  end

  // ---------------- driver ----------------
  task automatic run_req(input bit rd, input logic [3:0] a, input logic [3:0] d,
                         input logic [7:0] rb);
    automatic int target = rsp_seen + 1;
    slv_rbyte = rb;
    if (rd) begin
      exp_frames.push_back(8'h60 | {4'h0, a});
      exp_rsp.push_back(rb[3:0]);
    end else begin
      exp_frames.push_back(8'h20 | {4'h0, a});
      exp_frames.push_back(8'h10 | {4'h0, d});
      exp_rsp.push_back(4'h0);
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_is_read = rd; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_addr = ~a; req_wdata = ~d;
    check(!req_ready, "R2", "ready after accept", req_ready, 0);
    while (rsp_seen < target) @(negedge clk);
    @(negedge clk);
    check(!rsp_valid, "R9", "response pulse width", rsp_valid, 0);
    check(req_ready, "R2", "ready after response", req_ready, 1);
  endtask

  bit finished = 0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(sclk, "R1", "sclk in reset", sclk, 1);
    check(!sdo_oe, "R1", "drive enable in reset", sdo_oe, 0);
    check(req_ready, "R1", "ready in reset", req_ready, 1);
    check(!rsp_valid, "R1", "response in reset", rsp_valid, 0);
    rst = 0;
    @(negedge clk);
    // R10
    check(ce_out == 1'b0, "R10", "chip enable low", ce_out, 0);
    ce_in = 1; #1;
    check(ce_out == 1'b1, "R10", "chip enable high", ce_out, 1);

    // R5 writes
    run_req(0, 4'hE, 4'h7, 8'h00);
    run_req(0, 4'h0, 4'hF, 8'h00);
    run_req(0, 4'h5, 4'hA, 8'h00);
    // R6 R7 reads
    run_req(1, 4'h3, 4'h0, 8'hA5);
    run_req(1, 4'hF, 4'h0, 8'h3C);
    run_req(1, 4'h8, 4'h0, 8'hF0);
    run_req(1, 4'h0, 4'h0, 8'h0F);

    // R2: competing request while busy is ignored
    fork
      run_req(1, 4'hC, 4'h0, 8'h96);
      begin
        repeat (10) @(negedge clk);
        req_valid = 1; req_is_read = 0; req_addr = 4'h9; req_wdata = 4'h2;
        for (int i = 0; i < 100; i++) begin
          @(negedge clk);
          if (i % 25 == 0)
            check(!req_ready, "R2", "ready while busy", req_ready, 0);
        end
        req_valid = 0;
      end
    join

    // R11: reset in the middle of a write frame
    @(negedge clk);
    req_valid = 1; req_is_read = 0; req_addr = 4'h2; req_wdata = 4'h6;
    @(negedge clk);
    req_valid = 0;
    repeat (3 * PH) @(negedge clk);
    check(sdo_oe, "R11", "drive enable before abort", sdo_oe, 1);
    rst = 1;
    @(negedge clk);
    check(sclk, "R11", "sclk after abort", sclk, 1);
    check(!sdo_oe, "R11", "drive enable after abort", sdo_oe, 0);
    check(req_ready, "R11", "ready after abort", req_ready, 1);
    repeat (2) @(negedge clk);
    rst = 0;
    run_req(1, 4'h6, 4'h0, 8'h5B);
    run_req(0, 4'h7, 4'h1, 8'h00);

    repeat (4 * PH) @(negedge clk);
    check(exp_frames.size() == 0, "R5 R6", "frames left over", exp_frames.size(), 0);
    check(exp_rsp.size() == 0, "R9", "responses left over", exp_rsp.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule